// File: doc/BRIEF.md
# Speed-Adaptive Step Position Counter

This block converts single-cycle step strobes from a debounced rotary control into moves of a 10-bit position code. Each strobe carries a direction level. The block measures how long it has been since the previous strobe, counted in ticks of an external timing strobe. It sorts that interval into one of three rate bands. Slow turning moves the code by one. Moderate turning moves it by a mid step of 10. Fast turning moves it by a big step of 100.

A move is not applied in one jump. The block runs a burst of single count pulses into a saturating up/down counter, one pulse per clock, and a busy flag covers the burst. A strobe that arrives during a burst is either held in a one-deep slot or discarded, depending on a parameter. In potentiometer mode a second output shows the bitwise complement of the code. When the mode is switched off, that output freezes at the value it last showed.

Top module: `step_rate_pot`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `code_o` = 512, `busy_o` = 0 and an internal complement hold of 511. With `pot_en_i` high, `twin_o` then reads 511.
- R2: A strobe is in the slow band when at least SLOW_TICKS (100) ticks have been counted since the previous strobe. The first strobe after reset is also in the slow band. A slow-band strobe moves the code by exactly 1.
- R3: A strobe is in the middle band when at least FAST_TICKS (40) and fewer than SLOW_TICKS ticks have been counted since the previous strobe. A middle-band strobe moves the code by MID_STEP (10).
- R4: A strobe is in the fast band when fewer than FAST_TICKS ticks have been counted since the previous strobe. A fast-band strobe moves the code by BIG_STEP (100).
- R5: `dir_i` is sampled together with the strobe. A value of 1 makes every pulse of that burst add one, and 0 makes every pulse subtract one.
- R6: The code saturates at 0 and at 1023 and never wraps. The pulses of a burst that would overshoot leave the code at the limit.
- R7: When a strobe is accepted at an idle edge, `busy_o` goes high in the next cycle and stays high for exactly the burst length. The code changes by at most one per cycle, and only in the cycle after a busy cycle.
- R8: With QUEUE_EN = 1, the first strobe that arrives during a burst is stored with its own band and direction and runs straight after the current burst. Any further strobe while the slot is full is discarded. With QUEUE_EN = 0, every strobe that arrives during a burst is discarded.
- R9: While `pot_en_i` is high, `twin_o` equals the bitwise inverse of `code_o` in the same cycle.
- R10: While `pot_en_i` is low, `twin_o` holds the value it had in the last cycle in which `pot_en_i` was high.
- R11: Every strobe restarts the interval measurement, including a strobe that is discarded. The tick count saturates at SLOW_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One-cycle step strobe |
| dir_i | input | 1 | Direction of the strobe, 1 = up |
| tick_i | input | 1 | Timing strobe for interval measurement |
| pot_en_i | input | 1 | Potentiometer mode enable |
| code_o | output | 10 | Position code |
| twin_o | output | 10 | Complemented code (held when mode is off) |
| busy_o | output | 1 | High while a burst of count pulses runs |

## Verification
The interesting collision is a new strobe arriving in the same cycle as the final pulse of a burst. In that cycle, burst completion, loading of the slot and acceptance of the strobe all compete. The bench provokes it by timing a second strobe exactly ten cycles after a middle-band strobe, with both a queuing and a dropping instance under the same stimulus. The strobe must load at once with no idle gap, so the final codes of the two instances reveal whether it was lost or run twice. A behavioural model, built on integers and queues, judges every cycle, and directed end-of-move checks back it up.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int BURST_W = 8;

    typedef enum logic [1:0] {
        BAND_SLOW = 2'd0,
        BAND_MID  = 2'd1,
        BAND_FAST = 2'd2
    } rate_band_e;

    typedef struct packed {
        logic               up;
        logic [BURST_W-1:0] len;
    } burst_req_t;

    function automatic rate_band_e classify(int unsigned ivl,
                                            int unsigned slow_t,
                                            int unsigned fast_t);
        if (ivl >= slow_t)      return BAND_SLOW;
        else if (ivl >= fast_t) return BAND_MID;
        else                    return BAND_FAST;
    endfunction

    function automatic logic [BURST_W-1:0] band_len(rate_band_e b,
                                                    int unsigned mid_n,
                                                    int unsigned big_n);
        case (b)
            BAND_MID:  return BURST_W'(mid_n);
            BAND_FAST: return BURST_W'(big_n);
            default:   return BURST_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/srp_interval_meter.sv
module srp_interval_meter
    import srp_pkg::*;
#(
    parameter int SLOW_TICKS = 100,
    parameter int FAST_TICKS = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       step_i,
    output rate_band_e band_o
);
    localparam int IVL_W = $clog2(SLOW_TICKS + 1);
    localparam logic [IVL_W-1:0] IVL_TOP = IVL_W'(SLOW_TICKS);

    logic [IVL_W-1:0] ivl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= IVL_TOP;
        end else if (step_i) begin
            ivl_q <= '0;
        end else if (tick_i && (ivl_q != IVL_TOP)) begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    assign band_o = classify(32'(ivl_q), SLOW_TICKS, FAST_TICKS);

endmodule

// File: rtl/srp_burst_engine.sv
module srp_burst_engine
    import srp_pkg::*;
#(
    parameter bit QUEUE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic               dir_i,
    input  logic [BURST_W-1:0] len_i,
    output logic               pulse_o,
    output logic               pulse_up_o,
    output logic               busy_o
);
    logic [BURST_W-1:0] rem_q, rem_d, rem_after;
    logic               up_q, up_d;
    burst_req_t         fresh;
    burst_req_t         slot;
    logic               slot_v;
    logic               push, pop;

    assign fresh.up  = dir_i;
    assign fresh.len = len_i;

    assign busy_o     = (rem_q != '0);
    assign pulse_o    = busy_o;
    assign pulse_up_o = up_q;

    always_comb begin
        rem_after = rem_q - BURST_W'(busy_o);
        rem_d     = rem_after;
        up_d      = up_q;
        push      = 1'b0;
        pop       = 1'b0;
        if (rem_after == '0) begin
            if (slot_v) begin
                rem_d = slot.len;
                up_d  = slot.up;
                pop   = 1'b1;
                push  = step_i;
            end else if (step_i) begin
                rem_d = fresh.len;
                up_d  = fresh.up;
            end
        end else begin
            push = step_i && !slot_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            up_q  <= 1'b1;
        end else begin
            rem_q <= rem_d;
            up_q  <= up_d;
        end
    end

    generate
        if (QUEUE_EN) begin : g_slot
            burst_req_t slot_q;
            logic       slot_v_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q   <= '0;
                    slot_v_q <= 1'b0;
                end else if (push) begin
                    slot_q   <= fresh;
                    slot_v_q <= 1'b1;
                end else if (pop) begin
                    slot_v_q <= 1'b0;
                end
            end
            assign slot   = slot_q;
            assign slot_v = slot_v_q;
        end else begin : g_noslot
            assign slot   = '0;
            assign slot_v = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/srp_sat_counter.sv
module srp_sat_counter #(
    parameter int W         = 10,
    parameter int RESET_VAL = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pulse_i,
    input  logic         up_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= W'(RESET_VAL);
        end else if (pulse_i) begin
            if (up_i && (code_q != TOP)) begin
                code_q <= code_q + 1'b1;
            end else if (!up_i && (code_q != '0)) begin
                code_q <= code_q - 1'b1;
            end
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/srp_twin_out.sv
module srp_twin_out #(
    parameter int W         = 10,
    parameter int RESET_VAL = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] twin_o
);
    localparam logic [W-1:0] HOLD_RST = ~W'(RESET_VAL);

    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= HOLD_RST;
        end else if (en_i) begin
            hold_q <= ~code_i;
        end
    end

    assign twin_o = en_i ? ~code_i : hold_q;

endmodule

// File: rtl/step_rate_pot.sv
module step_rate_pot
    import srp_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int RESET_CODE = 512,
    parameter int SLOW_TICKS = 100,
    parameter int FAST_TICKS = 40,
    parameter int MID_STEP   = 10,
    parameter int BIG_STEP   = 100,
    parameter bit QUEUE_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              dir_i,
    input  logic              tick_i,
    input  logic              pot_en_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] twin_o,
    output logic              busy_o
);
    rate_band_e         band;
    logic [BURST_W-1:0] burst_len;
    logic               pulse;
    logic               pulse_up;

    srp_interval_meter #(
        .SLOW_TICKS(SLOW_TICKS),
        .FAST_TICKS(FAST_TICKS)
    ) u_meter (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick_i),
        .step_i(step_i),
        .band_o(band)
    );

    assign burst_len = band_len(band, MID_STEP, BIG_STEP);

    srp_burst_engine #(
        .QUEUE_EN(QUEUE_EN)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step_i),
        .dir_i     (dir_i),
        .len_i     (burst_len),
        .pulse_o   (pulse),
        .pulse_up_o(pulse_up),
        .busy_o    (busy_o)
    );

    srp_sat_counter #(
        .W        (CODE_W),
        .RESET_VAL(RESET_CODE)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .pulse_i(pulse),
        .up_i   (pulse_up),
        .code_o (code_o)
    );

    srp_twin_out #(
        .W        (CODE_W),
        .RESET_VAL(RESET_CODE)
    ) u_twin (
        .clk   (clk),
        .rst   (rst),
        .en_i  (pot_en_i),
        .code_i(code_o),
        .twin_o(twin_o)
    );

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
    parameter int CODE_W     = 10,
    parameter int RESET_CODE = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              step_i,
    input logic              pot_en_i,
    input logic [CODE_W-1:0] code_o,
    input logic [CODE_W-1:0] twin_o,
    input logic              busy_o,
    input logic              pulse_up
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (code_o == CODE_W'(RESET_CODE)) && !busy_o); // R1

    AST_IDLE_HOLDS_CODE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(code_o)); // R7

    AST_BURST_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(step_i)); // R7

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pulse_up && code_o == TOP) |=> (code_o == TOP)); // R6

    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !pulse_up && code_o == '0) |=> (code_o == '0)); // R6

    AST_TWIN_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        pot_en_i |-> ((twin_o + code_o) == TOP)); // R9

    AST_TWIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!pot_en_i && $past(!pot_en_i)) |-> $stable(twin_o)); // R10

endmodule

bind step_rate_pot srp_checker #(
    .CODE_W    (CODE_W),
    .RESET_CODE(RESET_CODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step_i),
    .pot_en_i(pot_en_i),
    .code_o  (code_o),
    .twin_o  (twin_o),
    .busy_o  (busy_o),
    .pulse_up(pulse_up)
);

// File: tb/step_rate_pot_bench.sv
module srp_ref_model #(
    parameter bit QEN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic dir,
    input  logic tick,
    input  logic pot_en,
    output int   e_code,
    output int   e_twin,
    output int   e_busy
);
    int code, left, ivl, hold;
    bit going_up;
    int q_len[$];
    bit q_dir[$];

    always @(posedge clk) begin
        if (rst) begin
            code = 512; left = 0; ivl = 100; hold = 511; going_up = 1;
            q_len.delete(); q_dir.delete();
        end else begin
            int n;
            n = (ivl >= 100) ? 1 : ((ivl >= 40) ? 10 : 100);
            if (pot_en) hold = 1023 - code;
            if (left > 0) begin
                if (going_up) code = (code < 1023) ? code + 1 : code;
                else          code = (code > 0) ? code - 1 : code;
                left = left - 1;
            end
            if (left == 0) begin
                if (q_len.size() > 0) begin
                    left = q_len.pop_front();
                    going_up = q_dir.pop_front();
                    if (step && QEN) begin q_len.push_back(n); q_dir.push_back(dir); end
                end else if (step) begin
                    left = n; going_up = dir;
                end
            end else if (step && QEN && q_len.size() == 0) begin
                q_len.push_back(n); q_dir.push_back(dir);
            end
            if (step) ivl = 0;
            else if (tick && ivl < 100) ivl = ivl + 1;
        end
    end

    assign e_code = code;
    assign e_busy = (left > 0) ? 1 : 0;
    assign e_twin = pot_en ? (1023 - code) : hold;
endmodule

module step_rate_pot_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0;
    logic dir = 1'b1;
    logic tick = 1'b0;
    logic pot_en = 1'b1;

    logic [9:0] code_a, twin_a, code_b, twin_b;
    logic       busy_a, busy_b;
    int ea_code, ea_twin, ea_busy, eb_code, eb_twin, eb_busy;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    int tick_div = 0;
    bit started = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    step_rate_pot u_step_rate_pot (
        .clk(clk), .rst(rst), .step_i(step), .dir_i(dir), .tick_i(tick),
        .pot_en_i(pot_en), .code_o(code_a), .twin_o(twin_a), .busy_o(busy_a)
    );

    step_rate_pot #(.QUEUE_EN(1'b0)) u_step_rate_pot_drop (
        .clk(clk), .rst(rst), .step_i(step), .dir_i(dir), .tick_i(tick),
        .pot_en_i(pot_en), .code_o(code_b), .twin_o(twin_b), .busy_o(busy_b)
    );

    srp_ref_model #(.QEN(1'b1)) u_ref_a (
        .clk(clk), .rst(rst), .step(step), .dir(dir), .tick(tick), .pot_en(pot_en),
        .e_code(ea_code), .e_twin(ea_twin), .e_busy(ea_busy)
    );

    srp_ref_model #(.QEN(1'b0)) u_ref_b (
        .clk(clk), .rst(rst), .step(step), .dir(dir), .tick(tick), .pot_en(pot_en),
        .e_code(eb_code), .e_twin(eb_twin), .e_busy(eb_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // tick generator: one tick every 8 cycles, driven after the edge
    always @(posedge clk) begin
        #1;
        tick_div = (tick_div + 1) % 8;
        tick = (tick_div == 0);
    end

    // per-cycle comparison against the reference model, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (started) begin
            chk("R5 code(queue)", int'(code_a), ea_code);
            chk("R7 busy(queue)", int'(busy_a), ea_busy);
            chk(pot_en ? "R9 twin(queue)" : "R10 twin(queue)", int'(twin_a), ea_twin);
            chk("R8 code(drop)", int'(code_b), eb_code);
            chk("R8 busy(drop)", int'(busy_b), eb_busy);
            chk(pot_en ? "R9 twin(drop)" : "R10 twin(drop)", int'(twin_b), eb_twin);
        end
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic do_step(input bit d);
        step = 1'b1; dir = d;
        @(posedge clk); #1;
        step = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy_a || busy_b) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 8) @(posedge clk);
        #1;
    endtask

    task automatic move_check(input string tag, input bit d, input int exp);
        do_step(d);
        wait_idle();
        @(negedge clk);
        chk(tag, int'(code_a), exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        started = 1;
        @(negedge clk);
        chk("R1 code", int'(code_a), 512);
        chk("R1 twin", int'(twin_a), 511);
        chk("R1 busy", int'(busy_a), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        wait_ticks(5);
        move_check("R2 first step slow", 1'b1, 513);
        wait_ticks(110);
        move_check("R2 slow down step", 1'b0, 512);
        wait_ticks(60);
        move_check("R3 middle step", 1'b1, 522);
        wait_ticks(3);
        move_check("R4 fast step", 1'b1, 622);
        move_check("R4 fast step", 1'b1, 722);
        move_check("R4 fast step", 1'b1, 822);
        move_check("R4 fast step", 1'b1, 922);
        move_check("R4 fast step", 1'b1, 1022);
        move_check("R6 top saturation", 1'b1, 1023);

        pot_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            move_check("R5 fast down", 1'b0, 923 - 100 * k);
        end
        move_check("R6 bottom saturation", 1'b0, 0);
        @(negedge clk);
        chk("R10 twin frozen", int'(twin_a), 0);
        @(posedge clk); #1;
        pot_en = 1'b1;
        @(negedge clk);
        chk("R9 twin follows", int'(twin_a), 1023);
        @(posedge clk); #1;

        // overlap: one stored, one discarded (dropping instance discards both)
        do_step(1'b1);
        repeat (5) @(posedge clk); #1;
        do_step(1'b1);
        repeat (5) @(posedge clk); #1;
        do_step(1'b1);
        wait_idle();
        @(negedge clk);
        chk("R8 queued step ran", int'(code_a), 200);
        chk("R8 drop variant", int'(code_b), 100);
        @(posedge clk); #1;

        // discarded strobe restarted the interval, so this is fast
        do_step(1'b1);
        wait_idle();
        @(negedge clk);
        chk("R11 interval restart (queue)", int'(code_a), 300);
        chk("R11 interval restart (drop)", int'(code_b), 200);
        @(posedge clk); #1;

        // strobe in the cycle of the final pulse of a middle burst
        wait_ticks(60);
        do_step(1'b0);
        repeat (9) @(posedge clk); #1;
        do_step(1'b0);
        wait_idle();
        @(negedge clk);
        chk("R7 last-pulse overlap (queue)", int'(code_a), 190);
        chk("R7 last-pulse overlap (drop)", int'(code_b), 90);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule